// File: doc/BRIEF.md
# Host Mailbox Port

The block lets an external host processor and an internal core exchange words through a small shared bank of mailbox registers. The host reaches the bank through an asynchronous parallel bus. Three static strap inputs select how that bus behaves: the transfer width (byte or word), the strobe style (separate read and write strobes, or a direction select plus one data strobe), and the addressing (a separate 3-bit address, or an address sent on the data lines and captured while an address-latch-enable is high). The core reaches the same bank through a synchronous register port in its own clock domain.

All host pins are brought into the core clock through two-flop synchronisers. A host write takes effect when its synchronised strobe goes inactive. Each mailbox register keeps two flags: one for "written by the host, not yet read by the core" and one for "written by the core, not yet read by the host". The core can read both flag sets. A mask selects which host-written flags raise the core interrupt. A host write of the reset command bit produces a software reset pulse of fixed length toward the core.

Top module: `mbx_port`

## Requirements
- R1: Six 16-bit mailbox registers sit at address 0 to 5 on both sides. A word the host writes is read back by the core, and a word the core writes is read back by the host.
- R2: Address 6 returns the six host-wrote flags in bits 5:0, and address 7 returns the six core-wrote flags in bits 5:0, with all other bits zero. Core address 8 holds the interrupt mask in bits 5:0. Writes to address 6 and 7 change no flag.
- R3: A host write to register i sets host-wrote flag i, and a core read of i clears it. A core write to i sets core-wrote flag i, and the end of a host read of i clears it.
- R4: `coreIrq` is high exactly when some register i has both its host-wrote flag and its mask bit set.
- R5: With `strapByteMode`=1, a host write stores data bits 7:0 and loads zeros into bits 15:8.
- R6: During a host read, `hostDataOe` is 16'hFFFF in word mode and 16'h00FF in byte mode, with the data on the enabled bits. At all other times `hostDataOe` is zero.
- R7: With `strapStrobeMode`=0, `hostRdN` and `hostWrN` are separate active-low strobes. With `strapStrobeMode`=1, `hostRdN` is the direction select (1 read, 0 write) and `hostWrN` is an active-low data strobe.
- R8: With `strapMuxAddr`=1, the address is taken from `hostDataIn[2:0]` while `hostAle` is high, and `hostAddr` is ignored.
- R9: A host write to address 7 with bit 6 set drives `swReset` high for exactly 5 consecutive core cycles, once. The same value written by the core produces no pulse.
- R10: If a host write commits in the same core cycle as a core write to the same register, the host data is kept, the host-wrote flag is set, and the core-wrote flag is left unchanged.
- R11: While `hostCsN` is high, host strobes have no effect: no register or flag changes, and `hostAck` and `hostDataOe` stay low.
- R12: `hostAck` is high while a synchronised host access is in progress, from one cycle after the strobe is seen until the strobe is released.
- R13: After reset, all registers, flags and the mask are zero, and `coreIrq`, `swReset`, `hostAck` and `hostDataOe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| strapByteMode | input | 1 | 0 word transfers, 1 byte transfers |
| strapStrobeMode | input | 1 | 0 separate strobes, 1 direction select plus data strobe |
| strapMuxAddr | input | 1 | 0 separate address bus, 1 address on data lines latched by `hostAle` |
| hostCsN | input | 1 | Active-low host chip select |
| hostRdN | input | 1 | Read strobe, or direction select in strobe mode 1 |
| hostWrN | input | 1 | Write strobe, or data strobe in strobe mode 1 |
| hostAle | input | 1 | Address latch enable in multiplexed mode |
| hostAddr | input | 3 | Host register address in separate mode |
| hostDataIn | input | 16 | Host data (and address in multiplexed mode) toward the block |
| hostDataOut | output | 16 | Read data toward the host |
| hostDataOe | output | 16 | Per-bit output enable for `hostDataOut` |
| hostAck | output | 1 | Host access acknowledge |
| coreAddr | input | 4 | Core register address |
| coreWe | input | 1 | Core write enable |
| coreRe | input | 1 | Core read enable |
| coreWData | input | 16 | Core write data |
| coreRData | output | 16 | Core read data, valid the cycle after `coreRe` |
| coreIrq | output | 1 | Interrupt toward the core |
| swReset | output | 1 | Software reset pulse toward the core |

## Verification
The bench times a host write so that it commits in exactly the cycle a core write hits the same register. A design that lets the core win, or that also sets the core-wrote flag, shows the wrong word or a stray flag there. Byte-mode traffic is checked for zero-filled upper bits and an enable of 16'h00FF. A design that keeps stale upper bits or drives all 16 lines is caught by these checks. The bench also counts the exact width of the reset pulse and strobes with chip select released, so a pulse one cycle short or long, or a write that lands without chip select, shows up. Each of the eight strap combinations gets random traffic in which `hostAddr` is random during multiplexed addressing, so a design that reads the wrong address source sends the data to the wrong register.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DATA_W          = 16;
  localparam int BYTE_W          = 8;
  localparam int NUM_MBX         = 6;
  localparam int HOST_AW         = 3;
  localparam int CORE_AW         = 4;
  localparam int SYNC_STAGES     = 2;
  localparam int PULSE_LEN       = 5;
  localparam int ADDR_HOST_FLAGS = 6;
  localparam int ADDR_CORE_FLAGS = 7;
  localparam int ADDR_MASK       = 8;
  localparam int RESET_BIT       = 6;
  localparam int PULSE_W         = $clog2(PULSE_LEN + 1);

  // strobes from host control to the register datapath
  typedef struct packed {
    logic               wrCommit;
    logic [HOST_AW-1:0] wrAddr;
    logic [DATA_W-1:0]  wrData;
    logic               rdActive;
    logic               rdDone;
    logic [HOST_AW-1:0] rdAddr;
    logic               byteMode;
  } hostStrobe_t;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int WIDTH = 8,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < STAGES; k++) stage[k] <= RESET_VAL;
    end else begin
      stage[0] <= din;
      for (int k = 1; k < STAGES; k++) stage[k] <= stage[k-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/mbx_host_ctrl.sv
module mbx_host_ctrl
  import mbx_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               strapByteMode,
  input  logic               strapStrobeMode,
  input  logic               strapMuxAddr,
  input  logic               hostCsN,
  input  logic               hostRdN,
  input  logic               hostWrN,
  input  logic               hostAle,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [DATA_W-1:0]  hostDataIn,
  output hostStrobe_t        strb,
  output logic               hostAck,
  output logic               swReset
);
  localparam int SYNC_W = 4 + HOST_AW + DATA_W;
  localparam logic [SYNC_W-1:0] SYNC_RST = {4'b1110, {(HOST_AW + DATA_W){1'b0}}};

  logic [SYNC_W-1:0]  syncBus;
  logic               csS, rdS, wrS, aleS;
  logic [HOST_AW-1:0] addrS;
  logic [DATA_W-1:0]  dataS;

  mbx_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .RESET_VAL(SYNC_RST)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({hostCsN, hostRdN, hostWrN, hostAle, hostAddr, hostDataIn}),
    .dout (syncBus)
  );

  assign {csS, rdS, wrS, aleS, addrS, dataS} = syncBus;

  logic               rdAct, wrAct, prevRd, prevWr, wrCommit;
  logic [HOST_AW-1:0] aleAddr, addrCur, accAddr, rdHeld;
  logic [DATA_W-1:0]  accData, dataFill;
  logic [PULSE_W-1:0] pulseCnt;

  // decode the strobe personality
  always_comb begin
    if (strapStrobeMode) begin
      rdAct = !csS && !wrS && rdS;
      wrAct = !csS && !wrS && !rdS;
    end else begin
      rdAct = !csS && !rdS && wrS;
      wrAct = !csS && !wrS;
    end
  end

  assign addrCur  = strapMuxAddr ? aleAddr : addrS;
  assign dataFill = strapByteMode ? {{(DATA_W-BYTE_W){1'b0}}, dataS[BYTE_W-1:0]} : dataS;
  assign wrCommit = prevWr && !wrAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aleAddr <= '0;
      accAddr <= '0;
      accData <= '0;
      rdHeld  <= '0;
      prevWr  <= 1'b0;
      prevRd  <= 1'b0;
      hostAck <= 1'b0;
    end else begin
      if (aleS)  aleAddr <= dataS[HOST_AW-1:0];
      if (wrAct) begin
        accAddr <= addrCur;
        accData <= dataFill;
      end
      if (rdAct) rdHeld <= addrCur;
      prevWr  <= wrAct;
      prevRd  <= rdAct;
      hostAck <= rdAct || wrAct;
    end
  end

  // fixed-length reset pulse on the command bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (wrCommit && accAddr == HOST_AW'(ADDR_CORE_FLAGS)
                 && accData[RESET_BIT] && pulseCnt == '0) begin
      pulseCnt <= PULSE_W'(PULSE_LEN);
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign swReset = (pulseCnt != '0);

  always_comb begin
    strb.wrCommit = wrCommit;
    strb.wrAddr   = accAddr;
    strb.wrData   = accData;
    strb.rdActive = rdAct;
    strb.rdDone   = prevRd && !rdAct;
    strb.rdAddr   = rdAct ? addrCur : rdHeld;
    strb.byteMode = strapByteMode;
  end
endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  hostStrobe_t        strb,
  input  logic [CORE_AW-1:0] coreAddr,
  input  logic               coreWe,
  input  logic               coreRe,
  input  logic [DATA_W-1:0]  coreWData,
  output logic [DATA_W-1:0]  coreRData,
  output logic               coreIrq,
  output logic [DATA_W-1:0]  hostDataOut,
  output logic [DATA_W-1:0]  hostDataOe
);
  localparam logic [DATA_W-1:0] BYTE_OE = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

  logic [DATA_W-1:0]  mbx [NUM_MBX];
  logic [NUM_MBX-1:0] hostWrote, coreWrote, maskReg;
  logic [DATA_W-1:0]  hostView, coreView;

  for (genvar i = 0; i < NUM_MBX; i++) begin : g_slot
    logic hostHit, coreHit, coreRdHit, hostRdDone;
    assign hostHit    = strb.wrCommit && strb.wrAddr == HOST_AW'(i);
    assign coreHit    = coreWe && coreAddr == CORE_AW'(i);
    assign coreRdHit  = coreRe && coreAddr == CORE_AW'(i);
    assign hostRdDone = strb.rdDone && strb.rdAddr == HOST_AW'(i);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        mbx[i]       <= '0;
        hostWrote[i] <= 1'b0;
        coreWrote[i] <= 1'b0;
      end else begin
        if (hostHit)      mbx[i] <= strb.wrData;
        else if (coreHit) mbx[i] <= coreWData;

        if (hostHit)        hostWrote[i] <= 1'b1;
        else if (coreRdHit) hostWrote[i] <= 1'b0;

        if (coreHit && !hostHit) coreWrote[i] <= 1'b1;
        else if (hostRdDone)     coreWrote[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskReg <= '0;
    else if (coreWe && coreAddr == CORE_AW'(ADDR_MASK)) maskReg <= coreWData[NUM_MBX-1:0];
  end

  always_comb begin
    hostView = '0;
    for (int i = 0; i < NUM_MBX; i++)
      if (strb.rdAddr == HOST_AW'(i)) hostView = mbx[i];
    if (strb.rdAddr == HOST_AW'(ADDR_HOST_FLAGS)) hostView = DATA_W'(hostWrote);
    if (strb.rdAddr == HOST_AW'(ADDR_CORE_FLAGS)) hostView = DATA_W'(coreWrote);
  end

  always_comb begin
    coreView = '0;
    for (int i = 0; i < NUM_MBX; i++)
      if (coreAddr == CORE_AW'(i)) coreView = mbx[i];
    if (coreAddr == CORE_AW'(ADDR_HOST_FLAGS)) coreView = DATA_W'(hostWrote);
    if (coreAddr == CORE_AW'(ADDR_CORE_FLAGS)) coreView = DATA_W'(coreWrote);
    if (coreAddr == CORE_AW'(ADDR_MASK))       coreView = DATA_W'(maskReg);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreRData   <= '0;
      hostDataOut <= '0;
      hostDataOe  <= '0;
    end else begin
      if (coreRe) coreRData <= coreView;
      if (strb.rdActive) begin
        hostDataOut <= strb.byteMode ? (hostView & BYTE_OE) : hostView;
        hostDataOe  <= strb.byteMode ? BYTE_OE : {DATA_W{1'b1}};
      end else begin
        hostDataOut <= '0;
        hostDataOe  <= '0;
      end
    end
  end

  assign coreIrq = |(hostWrote & maskReg);
endmodule

// File: rtl/mbx_port.sv
module mbx_port
  import mbx_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               strapByteMode,
  input  logic               strapStrobeMode,
  input  logic               strapMuxAddr,
  input  logic               hostCsN,
  input  logic               hostRdN,
  input  logic               hostWrN,
  input  logic               hostAle,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [DATA_W-1:0]  hostDataIn,
  output logic [DATA_W-1:0]  hostDataOut,
  output logic [DATA_W-1:0]  hostDataOe,
  output logic               hostAck,
  input  logic [CORE_AW-1:0] coreAddr,
  input  logic               coreWe,
  input  logic               coreRe,
  input  logic [DATA_W-1:0]  coreWData,
  output logic [DATA_W-1:0]  coreRData,
  output logic               coreIrq,
  output logic               swReset
);
  hostStrobe_t strb;

  mbx_host_ctrl u_ctrl (
    .clk             (clk),
    .rstN            (rstN),
    .strapByteMode   (strapByteMode),
    .strapStrobeMode (strapStrobeMode),
    .strapMuxAddr    (strapMuxAddr),
    .hostCsN         (hostCsN),
    .hostRdN         (hostRdN),
    .hostWrN         (hostWrN),
    .hostAle         (hostAle),
    .hostAddr        (hostAddr),
    .hostDataIn      (hostDataIn),
    .strb            (strb),
    .hostAck         (hostAck),
    .swReset         (swReset)
  );

  mbx_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .coreAddr    (coreAddr),
    .coreWe      (coreWe),
    .coreRe      (coreRe),
    .coreWData   (coreWData),
    .coreRData   (coreRData),
    .coreIrq     (coreIrq),
    .hostDataOut (hostDataOut),
    .hostDataOe  (hostDataOe)
  );
endmodule

// File: rtl/mbx_port_checker.sv
module mbx_port_checker
  import mbx_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              strapByteMode,
  input logic              hostCsN,
  input logic [DATA_W-1:0] hostDataOe,
  input logic              hostAck,
  input logic              swReset
);
  logic [3:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= '0;
    else if (swReset) runLen <= (runLen == 4'hF) ? runLen : runLen + 1'b1;
    else runLen <= '0;
  end

  a_r6_byte_upper_float: assert property (@(posedge clk) disable iff (!rstN)
    (strapByteMode && |hostDataOe) |-> hostDataOe[DATA_W-1:BYTE_W] == '0);

  a_r12_drive_needs_ack: assert property (@(posedge clk) disable iff (!rstN)
    |hostDataOe |-> hostAck);

  a_r11_idle_cs_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (hostCsN && $past(hostCsN) && $past(hostCsN, 2) && $past(hostCsN, 3))
      |-> (!hostAck && hostDataOe == '0));

  a_r9_pulse_not_long: assert property (@(posedge clk) disable iff (!rstN)
    swReset |-> runLen < 4'(PULSE_LEN));

  a_r9_pulse_not_short: assert property (@(posedge clk) disable iff (!rstN)
    (!swReset && runLen != '0) |-> runLen == 4'(PULSE_LEN));
endmodule

bind mbx_port mbx_port_checker u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .strapByteMode (strapByteMode),
  .hostCsN       (hostCsN),
  .hostDataOe    (hostDataOe),
  .hostAck       (hostAck),
  .swReset       (swReset)
);

// File: tb/mbx_port_bench.sv
module mbx_port_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        strapByteMode = 1'b0, strapStrobeMode = 1'b0, strapMuxAddr = 1'b0;
  logic        hostCsN = 1'b1, hostRdN = 1'b1, hostWrN = 1'b1, hostAle = 1'b0;
  logic [2:0]  hostAddr = '0;
  logic [15:0] hostDataIn = '0;
  logic [15:0] hostDataOut, hostDataOe;
  logic        hostAck;
  logic [3:0]  coreAddr = '0;
  logic        coreWe = 1'b0, coreRe = 1'b0;
  logic [15:0] coreWData = '0;
  logic [15:0] coreRData;
  logic        coreIrq, swReset;

  always #5 clk = ~clk;

  mbx_port u_mbx_port (.*);

  int checks = 0, fails = 0;
  logic [15:0] mdl [6];
  logic [5:0]  hwM = '0, cwM = '0, maskM = '0;
  int pulses = 0, runNow = 0, lastRun = 0;

  always @(posedge clk) begin
    if (swReset) runNow++;
    else if (runNow != 0) begin lastRun = runNow; pulses++; runNow = 0; end
  end

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expHost(input int a);
    if (a < 6) return mdl[a];
    if (a == 6) return {10'd0, hwM};
    return {10'd0, cwM};
  endfunction

  function automatic logic [15:0] expCore(input int a);
    if (a < 8) return expHost(a);
    return {10'd0, maskM};
  endfunction

  function automatic bit expIrq();
    return |(hwM & maskM);
  endfunction

  task automatic setAddr(input int a);
    if (strapMuxAddr) begin
      @(negedge clk); hostDataIn = 16'(a); hostAle = 1'b1; hostAddr = 3'($urandom);
      repeat (4) @(negedge clk);
      hostAle = 1'b0;
      repeat (4) @(negedge clk);
    end else begin
      @(negedge clk); hostAddr = 3'(a);
    end
  endtask

  task automatic hostWrite(input int a, input logic [15:0] d);
    setAddr(a);
    @(negedge clk); hostCsN = 1'b0; hostDataIn = d;
    repeat (2) @(negedge clk);
    if (strapStrobeMode) begin hostRdN = 1'b0; @(negedge clk); hostWrN = 1'b0; end
    else hostWrN = 1'b0;
    repeat (5) @(negedge clk);
    check(hostAck === 1'b1, "R12 ack during write", 16'(hostAck), 16'd1);
    hostWrN = 1'b1;
    @(negedge clk); hostRdN = 1'b1;
    repeat (4) @(negedge clk);
    hostCsN = 1'b1;
    repeat (4) @(negedge clk);
    check(hostAck === 1'b0, "R12 ack released", 16'(hostAck), 16'd0);
    if (a < 6) begin
      mdl[a] = strapByteMode ? {8'h00, d[7:0]} : d;
      hwM[a] = 1'b1;
    end
  endtask

  task automatic hostRead(input int a, input string tag);
    logic [15:0] e, m;
    setAddr(a);
    @(negedge clk); hostCsN = 1'b0;
    repeat (2) @(negedge clk);
    if (strapStrobeMode) hostWrN = 1'b0;
    else hostRdN = 1'b0;
    repeat (5) @(negedge clk);
    m = strapByteMode ? 16'h00FF : 16'hFFFF;
    e = expHost(a) & m;
    check((hostDataOut & m) === e, tag, hostDataOut & m, e);
    check(hostDataOe === m, "R6 output enable", hostDataOe, m);
    hostRdN = 1'b1; hostWrN = 1'b1;
    repeat (4) @(negedge clk);
    check(hostDataOe === 16'h0, "R6 enable off after read", hostDataOe, 16'h0);
    hostCsN = 1'b1;
    repeat (4) @(negedge clk);
    if (a < 6) cwM[a] = 1'b0;
  endtask

  task automatic coreWrite(input int a, input logic [15:0] d);
    @(negedge clk); coreAddr = 4'(a); coreWData = d; coreWe = 1'b1;
    @(negedge clk); coreWe = 1'b0;
    if (a < 6) begin mdl[a] = d; cwM[a] = 1'b1; end
    else if (a == 8) maskM = d[5:0];
  endtask

  task automatic coreRead(input int a, input string tag);
    logic [15:0] e;
    e = expCore(a);
    @(negedge clk); coreAddr = 4'(a); coreRe = 1'b1;
    @(negedge clk); coreRe = 1'b0;
    check(coreRData === e, tag, coreRData, e);
    if (a < 6) hwM[a] = 1'b0;
  endtask

  task automatic setStraps(input bit b, input bit s, input bit m);
    @(negedge clk);
    strapByteMode = b; strapStrobeMode = s; strapMuxAddr = m;
    hostRdN = 1'b1; hostWrN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seedVal;
    int p0;
    seedVal = $urandom(32'd4242);
    for (int i = 0; i < 6; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R13 reset state
    check(coreIrq === 1'b0 && swReset === 1'b0, "R13 irq and reset low", {14'd0, coreIrq, swReset}, 16'd0);
    check(hostAck === 1'b0 && hostDataOe === 16'h0, "R13 host outputs idle", hostDataOe, 16'h0);
    for (int a = 0; a < 9; a++) coreRead(a, "R13 register zero after reset");

    // R1 R3 basic word exchange, separate strobes
    hostWrite(2, 16'hBEEF);
    coreRead(6, "R3 host-wrote flag set");
    coreRead(2, "R1 core sees host word");
    coreRead(6, "R3 host-wrote flag cleared by core read");
    coreWrite(4, 16'h1234);
    hostRead(7, "R3 core-wrote flag set");
    hostRead(4, "R1 host sees core word");
    hostRead(7, "R3 core-wrote flag cleared by host read");

    // R2 writes to the flag addresses change nothing
    hostWrite(0, 16'h0001);
    hostWrite(6, 16'h0000);
    coreWrite(7, 16'h003F); // model: no change
    coreRead(6, "R2 flag write ignored");
    coreRead(7, "R2 core flag write ignored");

    // R10 same-cycle collision
    @(negedge clk); hostAddr = 3'd3;
    @(negedge clk); hostCsN = 1'b0; hostDataIn = 16'hA5A5;
    repeat (2) @(negedge clk); hostWrN = 1'b0;
    repeat (5) @(negedge clk); hostWrN = 1'b1;
    @(negedge clk);
    @(negedge clk); coreAddr = 4'd3; coreWData = 16'h5A5A; coreWe = 1'b1;
    @(negedge clk); coreWe = 1'b0;
    repeat (3) @(negedge clk); hostCsN = 1'b1;
    repeat (3) @(negedge clk);
    mdl[3] = 16'hA5A5; hwM[3] = 1'b1;
    coreRead(7, "R10 core flag untouched on collision");
    coreRead(6, "R10 host flag set on collision");
    coreRead(3, "R10 host data wins");

    // R11 strobes ignored with chip select high
    @(negedge clk); hostAddr = 3'd1; hostDataIn = 16'hFFFF; hostWrN = 1'b0;
    repeat (5) @(negedge clk);
    check(hostAck === 1'b0, "R11 no ack without select", 16'(hostAck), 16'd0);
    hostWrN = 1'b1; hostRdN = 1'b0;
    repeat (5) @(negedge clk);
    check(hostDataOe === 16'h0, "R11 no drive without select", hostDataOe, 16'h0);
    hostRdN = 1'b1;
    repeat (4) @(negedge clk);
    coreRead(1, "R11 register unchanged");
    coreRead(6, "R11 flags unchanged");

    // R9 reset pulse
    p0 = pulses;
    coreWrite(7, 16'h0040);
    repeat (10) @(negedge clk);
    check(pulses == p0, "R9 core write makes no pulse", 16'(pulses - p0), 16'd0);
    hostWrite(7, 16'h0000);
    repeat (10) @(negedge clk);
    check(pulses == p0, "R9 no pulse without command bit", 16'(pulses - p0), 16'd0);
    hostWrite(7, 16'h0040);
    repeat (10) @(negedge clk);
    check(pulses == p0 + 1, "R9 one pulse", 16'(pulses - p0), 16'd1);
    check(lastRun == 5, "R9 pulse length", 16'(lastRun), 16'd5);

    // R5 R6 byte mode
    setStraps(1'b1, 1'b0, 1'b0);
    hostWrite(5, 16'hABCD);
    coreRead(5, "R5 upper byte zero-filled");
    coreWrite(5, 16'h9876);
    hostRead(5, "R6 byte read low lane");

    // R7 R8 strobe and mux personalities
    setStraps(1'b0, 1'b1, 1'b1);
    hostWrite(1, 16'h0F0F);
    coreRead(1, "R7 R8 data-strobe write via latched address");
    hostRead(1, "R7 R8 data-strobe read via latched address");

    // R4 interrupt masking
    coreWrite(8, 16'h0002);
    hostWrite(1, 16'h1111);
    check(coreIrq === expIrq(), "R4 irq with mask set", 16'(coreIrq), 16'(expIrq()));
    coreWrite(8, 16'h0000);
    check(coreIrq === 1'b0, "R4 irq masked off", 16'(coreIrq), 16'd0);

    // random traffic across all strap combinations
    for (int ph = 0; ph < 8; ph++) begin
      setStraps(ph[0], ph[1], ph[2]);
      for (int n = 0; n < 30; n++) begin
        int op, a;
        logic [15:0] d;
        op = int'($urandom % 4);
        d  = 16'($urandom);
        case (op)
          0: begin a = int'($urandom % 6); hostWrite(a, d); end
          1: begin a = int'($urandom % 8); hostRead(a, "R1 R2 random host read"); end
          2: begin a = int'($urandom % 7); if (a == 6) a = 8; coreWrite(a, d); end
          default: begin a = int'($urandom % 9); coreRead(a, "R1 R3 random core read"); end
        endcase
        @(negedge clk);
        check(coreIrq === expIrq(), "R4 random irq", 16'(coreIrq), 16'(expIrq()));
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule